// File: doc/BRIEF.md
# Instruction Cycle Micro-Operation Sequencer

This block is the control sequencer of a small accumulator machine. It runs every instruction as a chain of timed register transfers between a memory address register, a memory buffer register, a program counter and an instruction register. Each transfer takes one state of an explicit state machine. Every instruction passes through a fetch subcycle and an execute subcycle. An indirect subcycle is added when the instruction asks for one, and an interrupt subcycle is added when a request is pending and interrupts are enabled.

Memory is reached through an address bus, a read strobe, a write strobe, a write data bus, a read data bus and a ready input. A transfer completes on the clock edge at which ready is high; until then the sequencer holds the strobe and the address. The instruction word is 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the address. A halt opcode freezes the sequencer until the next reset.

Top module: `ics_sequencer`

## Requirements
- R1: A synchronous reset sets the program counter to 0, clears the interrupt enable flag and puts the sequencer in the first fetch step. In that step neither strobe is active. On the next cycle a read of address 0 is requested.
- R2: A fetch copies the program counter into the address register, then drives a read at that address. While ready is low the read strobe and the address stay unchanged.
- R3: The program counter advances by exactly 1 per fetch, on the cycle the fetch read completes. It never changes while a read is stalled.
- R4: After a fetch the instruction register holds the fetched word unchanged.
- R5: When bit 15 is 1, the effective address is bits 11:0 of the memory word at the instruction's address field. That value replaces the instruction's address field before execute.
- R6: Opcode 1 loads the operand into the accumulator. Opcode 2 writes the accumulator to the effective address. Opcode 3 adds the operand to the accumulator, modulo 2^16.
- R7: Opcode 4 loads the program counter with the effective address.
- R8: Opcode 0 halts. After a halt no strobe is driven, and the program counter and accumulator stay unchanged until reset.
- R9: After execute, when a request is pending and interrupts are enabled, the sequencer writes the program counter to SAVE_ADDR. It then loads HANDLER_ADDR into the program counter and clears the enable flag. `irq_ack_o` pulses for one cycle in the final step of this subcycle.
- R10: With the enable flag clear, a pending request is never taken and memory at SAVE_ADDR is left untouched.
- R11: Opcode 5 sets the interrupt enable flag and opcode 6 clears it. The flag's new value already applies to the interrupt decision made at the end of that same instruction. Opcode 7 does nothing.
- R12: Read and write strobes are never active together. A write holds its address and data until ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr_o | output | ADDR_W | Memory address (address register) |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | DATA_W | Write data (buffer register) |
| mem_rdata_i | input | DATA_W | Read data |
| mem_ready_i | input | 1 | Transfer completes on this edge when high |
| irq_i | input | 1 | Interrupt request level |
| irq_ack_o | output | 1 | One-cycle pulse when the interrupt vector is taken |
| int_en_o | output | 1 | Interrupt enable flag |
| halted_o | output | 1 | Sequencer frozen by a halt |
| pc_o | output | ADDR_W | Program counter |
| ir_o | output | DATA_W | Instruction register |
| ac_o | output | DATA_W | Accumulator |

## Verification
A fetch needs three cycles with ready held high, and each cycle of stall adds one. An indirect subcycle adds three cycles, and an interrupt subcycle adds three. Execute takes three cycles for a load or an add, two for a store and one for any other opcode. The program counter takes the handler address one cycle after the acknowledge pulse. Because the latency varies with random stalls, the bench drives and samples on the falling edge. It checks stall hold one sample after each stalled cycle and the vector one sample after each acknowledge. Architectural results (accumulator, program counter, instruction register, memory) are compared only once the halt output is seen.

// File: rtl/ics_pkg.sv
package ics_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [3:0] {
      S_F1, S_F2, S_F3,
      S_N1, S_N2, S_N3,
      S_X1, S_X2, S_X3,
      S_I1, S_I2, S_I3,
      S_HALT
   } ics_state_e;

   localparam logic [OPC_W-1:0] OP_HALT  = 3'd0;
   localparam logic [OPC_W-1:0] OP_LOAD  = 3'd1;
   localparam logic [OPC_W-1:0] OP_STORE = 3'd2;
   localparam logic [OPC_W-1:0] OP_ADD   = 3'd3;
   localparam logic [OPC_W-1:0] OP_JUMP  = 3'd4;
   localparam logic [OPC_W-1:0] OP_EI    = 3'd5;
   localparam logic [OPC_W-1:0] OP_DI    = 3'd6;
   localparam logic [OPC_W-1:0] OP_NOP   = 3'd7;

endpackage

// File: rtl/ics_step_ctrl.sv
module ics_step_ctrl
   import ics_pkg::*;
#(
   parameter bit INDIRECT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ready_i,
   input  logic             irq_i,
   input  logic             ind_bit_i,
   input  logic [OPC_W-1:0] opcode_i,
   output ics_state_e       state_o,
   output logic             int_en_o
);

   ics_state_e st, nxt;
   logic       ie, ie_nxt, done, use_ind;

   generate
      if (INDIRECT_EN) begin : g_ind
         assign use_ind = ind_bit_i;
      end else begin : g_dir
         assign use_ind = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt    = st;
      ie_nxt = ie;
      done   = 1'b0;
      case (st)
         S_F1: nxt = S_F2;
         S_F2: if (ready_i) nxt = S_F3;
         S_F3: nxt = use_ind ? S_N1 : S_X1;
         S_N1: nxt = S_N2;
         S_N2: if (ready_i) nxt = S_N3;
         S_N3: nxt = S_X1;
         S_X1: begin
            case (opcode_i)
               OP_HALT:                  nxt = S_HALT;
               OP_LOAD, OP_ADD, OP_STORE: nxt = S_X2;
               OP_EI: begin ie_nxt = 1'b1; done = 1'b1; end
               OP_DI: begin ie_nxt = 1'b0; done = 1'b1; end
               default:                  done = 1'b1;
            endcase
         end
         S_X2: if (ready_i) begin
            if (opcode_i == OP_STORE) done = 1'b1;
            else                      nxt  = S_X3;
         end
         S_X3: done = 1'b1;
         S_I1: nxt = S_I2;
         S_I2: if (ready_i) nxt = S_I3;
         S_I3: begin ie_nxt = 1'b0; nxt = S_F1; end
         S_HALT: nxt = S_HALT;
         default: nxt = S_F1;
      endcase
      if (done) nxt = (irq_i && ie_nxt) ? S_I1 : S_F1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st <= S_F1;
         ie <= 1'b0;
      end else begin
         st <= nxt;
         ie <= ie_nxt;
      end
   end

   assign state_o  = st;
   assign int_en_o = ie;

endmodule

// File: rtl/ics_regs.sv
module ics_regs
   import ics_pkg::*;
#(
   parameter int                DATA_W       = 16,
   parameter int                ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FF,
   parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
   input  logic              clk,
   input  logic              rst,
   input  ics_state_e        state_i,
   input  logic              ready_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] mar_o,
   output logic [DATA_W-1:0] mbr_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] ir_o,
   output logic [DATA_W-1:0] ac_o
);

   localparam int OP_LSB = ADDR_W;

   logic [ADDR_W-1:0] mar, pc;
   logic [DATA_W-1:0] mbr, ir, ac;
   logic [OPC_W-1:0]  op;
   logic [ADDR_W-1:0] field;

   assign op    = ir[OP_LSB +: OPC_W];
   assign field = ir[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         mar <= '0;
         mbr <= '0;
         pc  <= '0;
         ir  <= '0;
         ac  <= '0;
      end else begin
         case (state_i)
            S_F1: mar <= pc;
            S_F2: if (ready_i) begin
               mbr <= rdata_i;
               pc  <= pc + ADDR_W'(1);
            end
            S_F3: ir <= mbr;
            S_N1: mar <= field;
            S_N2: if (ready_i) mbr <= rdata_i;
            S_N3: ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
            S_X1: begin
               case (op)
                  OP_LOAD, OP_ADD: mar <= field;
                  OP_STORE: begin
                     mar <= field;
                     mbr <= ac;
                  end
                  OP_JUMP: pc <= field;
                  default: ;
               endcase
            end
            S_X2: if (ready_i && op != OP_STORE) mbr <= rdata_i;
            S_X3: begin
               if (op == OP_LOAD)     ac <= mbr;
               else if (op == OP_ADD) ac <= ac + mbr;
            end
            S_I1: begin
               mar <= SAVE_ADDR;
               mbr <= DATA_W'(pc);
            end
            S_I3: pc <= HANDLER_ADDR;
            default: ;
         endcase
      end
   end

   assign mar_o = mar;
   assign mbr_o = mbr;
   assign pc_o  = pc;
   assign ir_o  = ir;
   assign ac_o  = ac;

endmodule

// File: rtl/ics_sequencer.sv
module ics_sequencer
   import ics_pkg::*;
#(
   parameter int                DATA_W       = 16,
   parameter int                ADDR_W       = 12,
   parameter bit                INDIRECT_EN  = 1'b1,
   parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'h0FF,
   parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic              mem_ready_i,
   input  logic              irq_i,
   output logic              irq_ack_o,
   output logic              int_en_o,
   output logic              halted_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] ir_o,
   output logic [DATA_W-1:0] ac_o
);

   localparam int IND_BIT = DATA_W - 1;
   localparam int OP_LSB  = ADDR_W;

   generate
      if (DATA_W != ADDR_W + OPC_W + 1) begin : g_bad_format
         $error("ics_sequencer: DATA_W must equal ADDR_W + OPC_W + 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ics_sequencer: ADDR_W too small");
      end
   endgenerate

   ics_state_e        state;
   logic [DATA_W-1:0] mbr, ir;
   logic [OPC_W-1:0]  op;

   assign op = ir[OP_LSB +: OPC_W];

   ics_step_ctrl #(
      .INDIRECT_EN(INDIRECT_EN)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .ready_i  (mem_ready_i),
      .irq_i    (irq_i),
      .ind_bit_i(mbr[IND_BIT]),
      .opcode_i (op),
      .state_o  (state),
      .int_en_o (int_en_o)
   );

   ics_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .SAVE_ADDR   (SAVE_ADDR),
      .HANDLER_ADDR(HANDLER_ADDR)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .state_i(state),
      .ready_i(mem_ready_i),
      .rdata_i(mem_rdata_i),
      .mar_o  (mem_addr_o),
      .mbr_o  (mbr),
      .pc_o   (pc_o),
      .ir_o   (ir),
      .ac_o   (ac_o)
   );

   assign mem_rd_o    = (state == S_F2) || (state == S_N2) ||
                        ((state == S_X2) && (op != OP_STORE));
   assign mem_wr_o    = ((state == S_X2) && (op == OP_STORE)) || (state == S_I2);
   assign mem_wdata_o = mbr;
   assign irq_ack_o   = (state == S_I3);
   assign halted_o    = (state == S_HALT);
   assign ir_o        = ir;

endmodule

// File: rtl/ics_sequencer_chk.sv
module ics_sequencer_chk #(
   parameter int                DATA_W       = 16,
   parameter int                ADDR_W       = 12,
   parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              mem_ready_i,
   input logic              irq_ack_o,
   input logic              int_en_o,
   input logic              halted_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic [DATA_W-1:0] ac_o
);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc_o == '0) && !int_en_o && !halted_o && !mem_rd_o && !mem_wr_o);

   assert_read_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_o && !mem_ready_i) |=> mem_rd_o && $stable(mem_addr_o));

   assert_pc_stall_R3: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_o && !mem_ready_i) |=> $stable(pc_o));

   assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
      halted_o |=> halted_o && !mem_rd_o && !mem_wr_o && $stable(pc_o) && $stable(ac_o));

   assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
      irq_ack_o |=> (pc_o == HANDLER_ADDR) && !int_en_o && !irq_ack_o);

   assert_enabled_only_R10: assert property (@(posedge clk) disable iff (rst)
      irq_ack_o |-> int_en_o);

   assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_o && mem_wr_o));

   assert_write_hold_R12: assert property (@(posedge clk) disable iff (rst)
      (mem_wr_o && !mem_ready_i) |=> mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

endmodule

bind ics_sequencer ics_sequencer_chk #(
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .HANDLER_ADDR(HANDLER_ADDR)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .mem_addr_o (mem_addr_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .mem_wdata_o(mem_wdata_o),
   .mem_ready_i(mem_ready_i),
   .irq_ack_o  (irq_ack_o),
   .int_en_o   (int_en_o),
   .halted_o   (halted_o),
   .pc_o       (pc_o),
   .ac_o       (ac_o)
);

// File: tb/sim_ics_sequencer.sv
`timescale 1ns/1ps
module sim_ics_sequencer;

   localparam int DW = 16;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          mem_ready = 1'b1;
   logic          irq = 1'b0;
   logic          irq_ack, int_en, halted;
   logic [AW-1:0] pc;
   logic [DW-1:0] ir, ac;

   logic [DW-1:0] mem [0:1023];
   logic [DW-1:0] am  [0:1023];

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int acks   = 0;
   bit stall_mode = 1'b0;
   bit prev_stall = 1'b0;
   bit prev_ack   = 1'b0;
   logic [AW-1:0] prev_addr, prev_pc;

   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr[9:0]];

   ics_sequencer u0 (
      .clk(clk), .rst(rst),
      .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
      .irq_i(irq), .irq_ack_o(irq_ack), .int_en_o(int_en), .halted_o(halted),
      .pc_o(pc), .ir_o(ir), .ac_o(ac)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One clock: sample at the falling edge, then serve memory for the next edge.
   task automatic cyc();
      bit r;
      @(negedge clk);
      cycles++;
      if (prev_stall) begin
         chk(mem_rd && mem_addr == prev_addr, "R2 read hold", {mem_rd, 3'b0, mem_addr}, {4'h1, prev_addr});
         chk(pc == prev_pc, "R3 pc stable in stall", pc, prev_pc);
      end
      if (prev_ack) begin
         chk(pc == 12'h100 && !int_en, "R9 vector", {int_en, 3'b0, pc}, 32'h100);
      end
      r = stall_mode ? ($urandom % 3 != 0) : 1'b1;
      prev_stall = !rst && mem_rd && !r;
      prev_addr  = mem_addr;
      prev_pc    = pc;
      prev_ack   = !rst && irq_ack;
      if (!rst && mem_wr && r) mem[mem_addr[9:0]] = mem_wdata;
      if (!rst && irq_ack) begin
         acks++;
         irq = 1'b0;
      end
      mem_ready = r;
   endtask

   task automatic do_reset(input bit check_r1);
      rst = 1'b1;
      prev_stall = 1'b0;
      prev_ack = 1'b0;
      acks = 0;
      repeat (3) cyc();
      rst = 1'b0;
      if (check_r1) begin
         chk(pc == 0 && !int_en && !halted && !mem_rd && !mem_wr, "R1 reset state",
             {int_en, halted, mem_rd, mem_wr, 16'h0, pc}, 32'h0);
         cyc();
         chk(mem_rd && mem_addr == 0, "R1 first read at 0", {mem_rd, 3'b0, mem_addr}, 32'h1000);
      end
   endtask

   task automatic run_to_halt();
      int n = 0;
      while (!halted && n < 5000) begin
         cyc();
         n++;
      end
      chk(halted, "R8 reached halt", halted, 1);
   endtask

   task automatic check_freeze();
      logic [AW-1:0] p = pc;
      logic [DW-1:0] a = ac;
      bit bad = 1'b0;
      for (int i = 0; i < 8; i++) begin
         cyc();
         if (mem_rd || mem_wr || pc != p || ac != a || !halted) bad = 1'b1;
      end
      chk(!bad, "R8 frozen after halt", bad, 0);
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = '0;
   endtask

   // Instruction-level reference: R4..R7 semantics, no interrupts.
   task automatic model_run(output logic [DW-1:0] m_ac, output logic [AW-1:0] m_pc);
      logic [DW-1:0] w;
      logic [AW-1:0] ea;
      m_ac = '0;
      m_pc = '0;
      for (int i = 0; i < 1024; i++) am[i] = mem[i];
      for (int s = 0; s < 500; s++) begin
         w = am[m_pc[9:0]];
         m_pc = m_pc + 1;
         ea = w[11:0];
         if (w[15]) ea = am[ea[9:0]][11:0];
         case (w[14:12])
            3'd0: break;
            3'd1: m_ac = am[ea[9:0]];
            3'd2: am[ea[9:0]] = m_ac;
            3'd3: m_ac = m_ac + am[ea[9:0]];
            3'd4: m_pc = ea;
            default: ;
         endcase
      end
   endtask

   function automatic logic [DW-1:0] mk(input bit ind, input logic [2:0] op, input logic [AW-1:0] a);
      return {ind, op, a};
   endfunction

   task automatic random_program(input int idx);
      int len;
      logic [DW-1:0] halt_w;
      logic [DW-1:0] exp_ac;
      logic [AW-1:0] exp_pc;
      logic [2:0] tbl [8] = '{3'd1, 3'd2, 3'd3, 3'd1, 3'd3, 3'd5, 3'd6, 3'd7};
      bit mem_ok;
      clear_mem();
      len = 4 + ($urandom % 16);
      for (int k = 0; k < 16; k++) begin
         mem[10'h1F0 + k] = {4'($urandom), 12'h200 + 12'($urandom % 16)};
         mem[10'h200 + k] = 16'($urandom);
      end
      for (int i = 0; i < len; i++) begin
         if (($urandom % 8 == 0) && (i + 2 <= len))
            mem[i] = mk(1'b0, 3'd4, 12'(i + 2));
         else if ($urandom % 3 == 0)
            mem[i] = mk(1'b1, tbl[$urandom % 8], 12'h1F0 + 12'($urandom % 16));
         else
            mem[i] = mk(1'b0, tbl[$urandom % 8], 12'h200 + 12'($urandom % 16));
      end
      halt_w = {4'b0000, 12'($urandom)};
      mem[len] = halt_w;
      model_run(exp_ac, exp_pc);
      stall_mode = idx[0];
      do_reset(idx == 0);
      run_to_halt();
      chk(ac == exp_ac, "R6 accumulator", ac, exp_ac);
      chk(pc == exp_pc, "R3/R7 program counter", pc, exp_pc);
      chk(ir == halt_w, "R4 instruction register", ir, halt_w);
      mem_ok = 1'b1;
      for (int k = 0; k < 16; k++) if (mem[10'h200 + k] != am[10'h200 + k]) mem_ok = 1'b0;
      chk(mem_ok, "R5/R6 data memory", mem_ok, 1);
      check_freeze();
   endtask

   task automatic load_irq_prog(input logic [DW-1:0] first);
      clear_mem();
      mem[0] = first;
      mem[1] = mk(1'b0, 3'd1, 12'h200);
      mem[2] = mk(1'b0, 3'd3, 12'h201);
      mem[3] = mk(1'b0, 3'd2, 12'h202);
      mem[4] = 16'h0000;
      mem[10'h100] = mk(1'b0, 3'd7, 12'h000);
      mem[10'h101] = mk(1'b0, 3'd5, 12'h000);
      mem[10'h102] = mk(1'b1, 3'd4, 12'h0FF);
      mem[10'h200] = 16'h1234;
      mem[10'h201] = 16'h0101;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      bit saw_ie;
      void'($urandom(32'd20240611));
      clear_mem();

      for (int p = 0; p < 24; p++) random_program(p);

      // R9/R11: EI with a pending request takes the interrupt at once;
      // handler returns through an indirect jump on the saved PC.
      load_irq_prog(mk(1'b0, 3'd5, 12'h000));
      stall_mode = 1'b1;
      do_reset(1'b0);
      irq = 1'b1;
      run_to_halt();
      chk(acks == 1, "R9 single acknowledge", acks, 1);
      chk(mem[10'h0FF] == 16'h0001, "R9 saved PC", mem[10'h0FF], 16'h0001);
      chk(mem[10'h202] == 16'h1335, "R6 store after return", mem[10'h202], 16'h1335);
      chk(pc == 12'd5, "R9 return path", pc, 5);
      chk(int_en, "R11 handler EI", int_en, 1);

      // R10: request held with interrupts disabled is ignored.
      load_irq_prog(mk(1'b0, 3'd7, 12'h000));
      stall_mode = 1'b0;
      do_reset(1'b0);
      irq = 1'b1;
      run_to_halt();
      chk(acks == 0, "R10 no acknowledge", acks, 0);
      chk(mem[10'h0FF] == 16'h0000, "R10 save slot untouched", mem[10'h0FF], 0);
      chk(ac == 16'h1335, "R10 program result", ac, 16'h1335);
      irq = 1'b0;

      // R11: EI then DI with no request.
      clear_mem();
      mem[0] = mk(1'b0, 3'd5, 12'h000);
      mem[1] = mk(1'b0, 3'd7, 12'h000);
      mem[2] = mk(1'b0, 3'd6, 12'h000);
      mem[3] = 16'h0000;
      do_reset(1'b0);
      saw_ie = 1'b0;
      for (int n = 0; n < 200 && !halted; n++) begin
         cyc();
         if (int_en) saw_ie = 1'b1;
      end
      chk(saw_ie, "R11 EI sets enable", saw_ie, 1);
      chk(!int_en, "R11 DI clears enable", int_en, 0);
      check_freeze();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule